// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Frequency Divider

This block divides a fast input clock by a programmable integer and emits one pulse per division period for a downstream phase comparator. A digital prescaler counter can divide by 10 or by 11. A main down-counter counts prescaler periods. A swallow counter decides how many of those prescaler periods use the longer modulus. With the prescaler active, each output period lasts 10·(M+1)+A input cycles. With the prescaler bypassed, the main counter counts input cycles directly and the period is M+1 cycles.

The main value M is 9 bits wide and the swallow value A is 4 bits wide. A direct-control flag clears the two top bits of M. If A is larger than M+1, it is clamped to M+1 and an error flag is raised for that period. M, A, the bypass input and the direct flag are sampled only at a period boundary, which means on the cycle after reset and on every output pulse. New values therefore never corrupt a period already in progress.

The control is a four-state machine. `ST_IDLE` loads the inputs on the first cycle after reset. `ST_SWALLOW` runs the prescaler at modulus 11 while swallow counts remain. `ST_NORMAL` runs it at modulus 10. `ST_BYPASS` counts input cycles with the prescaler held. Its transitions are:

- IDLE→{SWALLOW | NORMAL | BYPASS} on the load, chosen by the bypass input and by whether the effective A is zero.
- SWALLOW→NORMAL when the last swallow count ends a prescaler period.
- SWALLOW/NORMAL/BYPASS→reload choice when the main counter reaches zero at the end of a period.

Top module: `psd_divider`

## Requirements
- R1: With `presc_off` low and A=0, the spacing between consecutive `div_pulse` assertions is 10·(M+1) input cycles.
- R2: With `presc_off` low and A≥1, the prescaler uses modulus 11 for the first A main counts and modulus 10 for the rest, so the pulse spacing is 10·(M+1)+A cycles.
- R3: With `presc_off` high, the pulse spacing is M+1 cycles. M=0 gives a pulse on every cycle, and no swallow counting takes place.
- R4: `div_pulse` is high for exactly one input cycle whenever the following period is longer than one cycle.
- R5: `m_val`, `a_val`, `presc_off` and `direct_mode` are sampled only in the cycle where `div_pulse` is high, or in the first cycle after reset. Changes at other times have no effect on the period in progress.
- R6: When `direct_mode` is high at a sampling cycle, bits 8 and 7 of `m_val` are treated as zero.
- R7: If A > M_eff+1 with the prescaler active, A is clamped to M_eff+1 and `a_err` is high for that whole period. Otherwise `a_err` is low, and it is always low in bypass.
- R8: During reset `div_pulse` and `a_err` are low. The first pulse after reset release arrives N cycles after the first active clock edge, where N is the period computed from the inputs at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being divided |
| rst_n | input | 1 | Active-low asynchronous reset |
| m_val | input | 9 | Main counter value M |
| a_val | input | 4 | Swallow value A |
| presc_off | input | 1 | High: bypass the prescaler and hold it idle |
| direct_mode | input | 1 | High: clear bits 8 and 7 of M |
| div_pulse | output | 1 | One-cycle pulse at the end of each division period |
| a_err | output | 1 | A was out of range and clamped for the current period |

## Verification
On every cycle, the assertions check the following:

- The prescaler count stays within its modulus.
- The machine is in the swallow state only while swallow counts remain.
- The swallow count never exceeds the main count plus one, which is the clamp.
- The main counter moves only by single decrements except at a pulse.
- A direct-mode load leaves M below 128.

Only the bench's scenarios can show the exact period lengths for each mode. The same applies to the effect of mid-period input changes and to the alignment of the error flag with the clamped period. The bench measures these as the distances between pulses, using the inputs present at each sampling cycle.

// File: rtl/psd_pkg.sv
package psd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_NORMAL  = 2'd2,
        ST_BYPASS  = 2'd3
    } psd_state_e;

endpackage

// File: rtl/psd_prog_fix.sv
// Turns raw M/A inputs into the values actually loaded: direct-mode masking
// of the upper M bits and clamping of A to M+1.
module psd_prog_fix #(
    parameter int MW          = 9,
    parameter int AW          = 4,
    parameter int DIRECT_BITS = 7
) (
    input  logic [MW-1:0] m_in,
    input  logic [AW-1:0] a_in,
    input  logic          direct,
    output logic [MW-1:0] m_eff,
    output logic [AW-1:0] a_eff,
    output logic          a_over
);
    localparam int CW = MW + 1;
    localparam logic [MW-1:0] DIRECT_MASK = MW'((1 << DIRECT_BITS) - 1);

    logic [CW-1:0] limit;
    logic [CW-1:0] a_wide;

    always_comb begin
        m_eff  = direct ? (m_in & DIRECT_MASK) : m_in;
        limit  = {1'b0, m_eff} + CW'(1);
        a_wide = CW'(a_in);
        a_over = a_wide > limit;
        a_eff  = a_over ? limit[AW-1:0] : a_in;
    end

endmodule

// File: rtl/psd_down_cnt.sv
// Loadable down-counter that stops at zero.
module psd_down_cnt #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] count,
    output logic         zero
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (dec && count != '0) begin
            count <= count - W'(1);
        end
    end

    assign zero = (count == '0);

endmodule

// File: rtl/psd_prescaler.sv
// Dual-modulus prescaler: counts PRE_DIV or PRE_DIV+1 cycles per period.
module psd_prescaler #(
    parameter int PRE_DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic reload,
    input  logic use_hi,
    output logic tc
);
    localparam int PW = $clog2(PRE_DIV + 2);
    localparam logic [PW-1:0] TOP_HI = PW'(PRE_DIV);
    localparam logic [PW-1:0] TOP_LO = PW'(PRE_DIV - 1);

    logic [PW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (reload) begin
            cnt <= use_hi ? TOP_HI : TOP_LO;
        end else if (run && cnt != '0) begin
            cnt <= cnt - PW'(1);
        end
    end

    assign tc = run && (cnt == '0);

    // R2
    presc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= TOP_HI);

endmodule

// File: rtl/psd_divider.sv
module psd_divider #(
    parameter int PRE_DIV     = 10,
    parameter int MW          = 9,
    parameter int AW          = 4,
    parameter int DIRECT_BITS = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [MW-1:0] m_val,
    input  logic [AW-1:0] a_val,
    input  logic          presc_off,
    input  logic          direct_mode,
    output logic          div_pulse,
    output logic          a_err
);
    import psd_pkg::*;

    localparam int CW = MW + 1;

    psd_state_e    st, st_nxt, st_pick;
    logic [MW-1:0] m_eff, m_cnt;
    logic [AW-1:0] a_eff, a_cnt, a_load;
    logic          a_over, m_zero, a_zero, a_gt1;
    logic          load, run, presc_tc, presc_reload, presc_hi;
    logic          m_step, a_step;

    psd_prog_fix #(.MW(MW), .AW(AW), .DIRECT_BITS(DIRECT_BITS)) i_fix (
        .m_in   (m_val),
        .a_in   (a_val),
        .direct (direct_mode),
        .m_eff  (m_eff),
        .a_eff  (a_eff),
        .a_over (a_over)
    );

    psd_down_cnt #(.W(MW)) i_main (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (m_eff),
        .dec      (m_step),
        .count    (m_cnt),
        .zero     (m_zero)
    );

    psd_down_cnt #(.W(AW)) i_swallow (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (a_load),
        .dec      (a_step),
        .count    (a_cnt),
        .zero     (a_zero)
    );

    psd_prescaler #(.PRE_DIV(PRE_DIV)) i_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .reload (presc_reload),
        .use_hi (presc_hi),
        .tc     (presc_tc)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    // Next state
    always_comb begin
        st_pick = presc_off ? ST_BYPASS : ((a_eff != '0) ? ST_SWALLOW : ST_NORMAL);
        st_nxt  = st;
        unique case (st)
            ST_IDLE: st_nxt = st_pick;
            ST_SWALLOW, ST_NORMAL: begin
                if (presc_tc) begin
                    if (m_zero)      st_nxt = st_pick;
                    else if (a_gt1)  st_nxt = ST_SWALLOW;
                    else             st_nxt = ST_NORMAL;
                end
            end
            ST_BYPASS: if (m_zero) st_nxt = st_pick;
        endcase
    end

    // Outputs and counter controls
    always_comb begin
        a_gt1        = a_cnt > AW'(1);
        run          = (st == ST_SWALLOW) || (st == ST_NORMAL);
        div_pulse    = m_zero && (presc_tc || (st == ST_BYPASS));
        load         = (st == ST_IDLE) || div_pulse;
        m_step       = !m_zero && (presc_tc || (st == ST_BYPASS));
        a_step       = presc_tc && !m_zero && !a_zero;
        a_load       = presc_off ? '0 : a_eff;
        presc_reload = (load && !presc_off) || (presc_tc && !m_zero);
        presc_hi     = load ? (a_eff != '0) : a_gt1;
    end

    // Range error flag, held for the whole period it describes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_err <= 1'b0;
        end else if (load) begin
            a_err <= a_over && !presc_off;
        end
    end

    // R2
    swallow_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SWALLOW) |-> !a_zero);

    // R7
    clamp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (CW'(a_cnt) <= ({1'b0, m_cnt} + CW'(1))));

    // R3
    bypass_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BYPASS) |-> a_zero);

    // R5
    no_midload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && !div_pulse) |=>
            (m_cnt == $past(m_cnt) || m_cnt == $past(m_cnt) - MW'(1)));

    // R4
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_pulse && !presc_off) |=> !div_pulse);

    // R6
    direct_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && direct_mode) |=> (m_cnt < MW'(1 << DIRECT_BITS)));

endmodule

// File: tb/test_psd_divider.sv
module test_psd_divider;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [8:0] m_val;
    logic [3:0] a_val;
    logic       presc_off, direct_mode;
    logic       div_pulse, a_err;

    always #2 clk = ~clk;

    psd_divider i_psd_divider (
        .clk         (clk),
        .rst_n       (rst_n),
        .m_val       (m_val),
        .a_val       (a_val),
        .presc_off   (presc_off),
        .direct_mode (direct_mode),
        .div_pulse   (div_pulse),
        .a_err       (a_err)
    );

    int    checks = 0, errors = 0, total = 0, since = 0, exp_n = 0;
    bit    exp_err, last_pulse, hung, saw;
    string tag;
    logic [8:0] nm, am;
    logic [3:0] na, aa;
    bit         noff, ndir, aoff, adir;

    function automatic int eff_m(logic [8:0] m, bit dir);
        return dir ? int'(m & 9'h07F) : int'(m);
    endfunction

    function automatic int exp_period(logic [8:0] m, logic [3:0] a, bit off, bit dir);
        int me, ae;
        me = eff_m(m, dir);
        if (off) return me + 1;
        ae = (int'(a) > me + 1) ? me + 1 : int'(a);
        return 10 * (me + 1) + ae;
    endfunction

    function automatic bit exp_flag(logic [8:0] m, logic [3:0] a, bit off, bit dir);
        return !off && (int'(a) > eff_m(m, dir) + 1);
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, expv, total);
        end
    endtask

    task automatic arm(string first_tag);
        am = m_val; aa = a_val; aoff = presc_off; adir = direct_mode;
        exp_n   = exp_period(am, aa, aoff, adir);
        exp_err = exp_flag(am, aa, aoff, adir);
        if (first_tag != "")  tag = first_tag;
        else if (aoff)        tag = "R3";
        else if (adir)        tag = "R6";
        else if (aa != 4'd0)  tag = "R2";
        else                  tag = "R1";
        since = 0;
    endtask

    task automatic step(bit rnd);
        string t;
        @(negedge clk);
        total++;
        since++;
        saw = div_pulse;
        if (last_pulse && exp_n > 1)
            check(div_pulse == 1'b0, "R4", int'(div_pulse), 0);
        last_pulse = div_pulse;
        if (div_pulse) begin
            t = (am != m_val || aa != a_val || aoff != presc_off || adir != direct_mode)
                ? {tag, "/R5"} : tag;
            check(since == exp_n, t, since, exp_n);
            check(a_err == exp_err, "R7", int'(a_err), int'(exp_err));
        end
        if (rnd && (div_pulse || $urandom_range(15) == 0)) begin
            na   = 4'($urandom_range(15));
            nm   = ($urandom_range(9) == 0) ? 9'($urandom_range(511)) : 9'($urandom_range(40));
            noff = ($urandom_range(3) == 0);
            ndir = ($urandom_range(4) == 0);
        end
        m_val = nm; a_val = na; presc_off = noff; direct_mode = ndir;
        if (div_pulse) arm("");
        if (since > 6000) begin
            check(1'b0, "watchdog", since, exp_n);
            hung = 1'b1;
        end
    endtask

    task automatic wait_pulses(int k, bit rnd);
        int got = 0;
        while (got < k && !hung) begin
            step(rnd);
            if (saw) got++;
        end
    endtask

    task automatic directed(logic [8:0] m, logic [3:0] a, bit off, bit dir);
        nm = m; na = a; noff = off; ndir = dir;
        wait_pulses(2, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        hung = 1'b0; last_pulse = 1'b0;
        nm = 9'd5; na = 4'd3; noff = 1'b0; ndir = 1'b0;
        m_val = nm; a_val = na; presc_off = noff; direct_mode = ndir;
        rst_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(div_pulse == 1'b0, "R8", int'(div_pulse), 0);
            check(a_err == 1'b0, "R8", int'(a_err), 0);
        end
        rst_n = 1'b1;
        arm("R8");                       // first period: 10*6+3 = 63
        wait_pulses(1, 1'b0);
        directed(9'd0,   4'd1,  1'b0, 1'b0);   // R2: 11
        directed(9'd0,   4'd0,  1'b0, 1'b0);   // R1: 10
        directed(9'd1,   4'd2,  1'b0, 1'b0);   // R2: A=M+1, 22
        directed(9'd511, 4'd15, 1'b0, 1'b0);   // R2: 5135
        directed(9'd0,   4'd7,  1'b1, 1'b0);   // R3: every cycle
        directed(9'd3,   4'd2,  1'b1, 1'b0);   // R3: 4
        directed(9'h1FF, 4'd5,  1'b0, 1'b1);   // R6: M->127, 1285
        directed(9'h080, 4'd1,  1'b0, 1'b1);   // R6: M->0, 11
        directed(9'd2,   4'd9,  1'b0, 1'b0);   // R7: clamp to 3, 33
        directed(9'd0,   4'd15, 1'b0, 1'b0);   // R7: clamp to 1, 11
        directed(9'd9,   4'd15, 1'b1, 1'b0);   // R7: no flag in bypass, 10
        wait_pulses(150, 1'b1);                // R5 mid-period changes mixed in
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule